// File: doc/BRIEF.md
# Cluster Activity Dispatcher with Load-Shared Processors

This block sits between the local token-matching store of one cluster and a small pool of execution processors. Each incoming activity carries a one-bit opcode (add or divide), a context tag and two operands. When a processor is free, the activity goes to the free processor with the lowest index. That processor holds the work for a fixed, opcode-dependent number of cycles and then returns one result token carrying the same context tag. Work is shared across clusters by load. A local activity that finds every processor busy is written into a three-entry queue that drains toward the inter-cluster network. A free processor takes an activity from the network input only when the local side presents nothing in that cycle.

Each processor is a two-state machine. PS_IDLE is the free state. The IDLE-to-RUN transition fires on a start pulse from the dispatcher and loads a countdown with the opcode's latency minus one. In PS_RUN the RUN-to-RUN transition decrements the count while it is non-zero. The RUN-to-IDLE transition fires in the cycle the count is zero, and that is the cycle in which the result token is presented. The dispatcher itself is combinational around these machines and the export queue.

Top module: `cluster_dispatch`

## Requirements
- R1: After reset every processor is idle, no result is presented, the export queue is empty (`net_out_valid` low), `loc_ready` is high, and `net_in_ready` is high while `loc_valid` is low.
- R2: An accepted activity starts the idle processor with the lowest index. Processor p then presents its result on bit p of `res_valid`, with its tag in `res_tag[p*TAG_W +: TAG_W]`.
- R3: An add activity (opcode 0) accepted at clock edge t gives a result token in the cycle after edge t+1, so the processor is busy for 2 cycles. The result data is (a + b) modulo 2^DATA_W, and the token carries the activity's tag.
- R4: A divide activity (opcode 1) keeps its processor busy for 60 cycles and presents its result in the last of them. The data is the integer quotient a / b, or all ones when b is 0.
- R5: A processor presents exactly one result per activity, accepts nothing while busy, and is idle again in the cycle after its result.
- R6: A valid local activity that finds no processor idle and the export queue not full is accepted into the queue. It appears on `net_out_*` no later than the next cycle.
- R7: The export queue holds 3 entries. When it holds 3 and no processor is idle, `loc_ready` is low. A pop in the same cycle does not free a slot until the next cycle.
- R8: `net_in_ready` is high only when some processor is idle and `loc_valid` is low. A local activity therefore has priority over a network activity in the same cycle.
- R9: The queue leaves in arrival order. The head is held stable while `net_out_ready` is low, and it is removed on a cycle with `net_out_valid` and `net_out_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local activity present |
| loc_ready | output | 1 | Local activity accepted this cycle |
| loc_op | input | 1 | Local opcode: 0 add, 1 divide |
| loc_tag | input | TAG_W | Local context tag |
| loc_opa | input | DATA_W | Local first operand |
| loc_opb | input | DATA_W | Local second operand |
| net_in_valid | input | 1 | Network activity present |
| net_in_ready | output | 1 | Network activity accepted this cycle |
| net_in_op | input | 1 | Network opcode |
| net_in_tag | input | TAG_W | Network context tag |
| net_in_opa | input | DATA_W | Network first operand |
| net_in_opb | input | DATA_W | Network second operand |
| net_out_valid | output | 1 | Exported activity present |
| net_out_ready | input | 1 | Network takes the exported activity |
| net_out_op | output | 1 | Exported opcode |
| net_out_tag | output | TAG_W | Exported tag |
| net_out_opa | output | DATA_W | Exported first operand |
| net_out_opb | output | DATA_W | Exported second operand |
| res_valid | output | NPROC | Per-processor result strobe |
| res_tag | output | NPROC*TAG_W | Per-processor result tags |
| res_data | output | NPROC*DATA_W | Per-processor result data |

## Verification
The hardest state to reach is a full export queue while every processor is busy, because it needs long divides in flight and a stalled network at the same time. A directed opening loads each processor with a divide while `net_out_ready` is held low. Local activities then follow until the fourth one stalls. Constrained random traffic with a fixed seed comes after, in a phase with heavy network backpressure and a phase with light backpressure. A cycle-level model built from the requirements predicts every ready signal, result token and queue head.

// File: rtl/cad_pkg.sv
package cad_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_DIV = 1'b1
    } op_e;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_RUN  = 1'b1
    } proc_state_e;
endpackage

// File: rtl/cad_pick.sv
module cad_pick #(
    parameter int N  = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  idle,
    output logic          any,
    output logic [IW-1:0] sel
);
    always_comb begin
        any = |idle;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (idle[i]) sel = IW'(i);
        end
    end
endmodule

// File: rtl/cad_fifo.sv
module cad_fifo #(
    parameter int W     = 21,
    parameter int DEPTH = 3,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/cad_proc.sv
module cad_proc
    import cad_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 8,
    parameter int ADD_LAT = 2,
    parameter int DIV_LAT = 60,
    localparam int MAXL   = (DIV_LAT > ADD_LAT) ? DIV_LAT : ADD_LAT,
    localparam int CW     = $clog2(MAXL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [TAG_W-1:0]  tag,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              busy,
    output logic              done,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data
);
    proc_state_e       state, nxt;
    logic [CW-1:0]     cnt;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] sum, quo;

    assign sum = opa + opb;
    assign quo = (opb == '0) ? '1 : opa / opb;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == PS_IDLE && start) begin
                cnt    <= (op == OP_DIV) ? CW'(DIV_LAT - 1) : CW'(ADD_LAT - 1);
                tag_q  <= tag;
                data_q <= (op == OP_DIV) ? quo : sum;
            end else if (state == PS_RUN && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            PS_IDLE: if (start)      nxt = PS_RUN;
            PS_RUN:  if (cnt == '0)  nxt = PS_IDLE;
            default: nxt = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            PS_IDLE: ;
            PS_RUN: begin
                busy = 1'b1;
                done = (cnt == '0);
            end
            default: ;
        endcase
    end

    assign res_tag  = tag_q;
    assign res_data = data_q;
endmodule

// File: rtl/cluster_dispatch.sv
module cluster_dispatch #(
    parameter int NPROC   = 3,
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 8,
    parameter int ADD_LAT = 2,
    parameter int DIV_LAT = 60,
    parameter int QDEPTH  = 3,
    localparam int IW     = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int AW     = 1 + TAG_W + 2 * DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      loc_valid,
    output logic                      loc_ready,
    input  logic                      loc_op,
    input  logic [TAG_W-1:0]          loc_tag,
    input  logic [DATA_W-1:0]         loc_opa,
    input  logic [DATA_W-1:0]         loc_opb,
    input  logic                      net_in_valid,
    output logic                      net_in_ready,
    input  logic                      net_in_op,
    input  logic [TAG_W-1:0]          net_in_tag,
    input  logic [DATA_W-1:0]         net_in_opa,
    input  logic [DATA_W-1:0]         net_in_opb,
    output logic                      net_out_valid,
    input  logic                      net_out_ready,
    output logic                      net_out_op,
    output logic [TAG_W-1:0]          net_out_tag,
    output logic [DATA_W-1:0]         net_out_opa,
    output logic [DATA_W-1:0]         net_out_opb,
    output logic [NPROC-1:0]          res_valid,
    output logic [NPROC*TAG_W-1:0]    res_tag,
    output logic [NPROC*DATA_W-1:0]   res_data
);
    logic [NPROC-1:0] busy_v;
    logic [NPROC-1:0] start_v;
    logic             any_idle;
    logic [IW-1:0]    sel;
    logic             q_empty, q_full, q_push, q_pop;
    logic [AW-1:0]    q_dout;
    logic             dispatch;
    logic             d_op;
    logic [TAG_W-1:0] d_tag;
    logic [DATA_W-1:0] d_opa, d_opb;

    cad_pick #(.N(NPROC)) u_pick (
        .idle (~busy_v),
        .any  (any_idle),
        .sel  (sel)
    );

    // dispatch decision: local first, export when full, pull remote when idle
    always_comb begin
        loc_ready    = any_idle || !q_full;
        net_in_ready = any_idle && !loc_valid;
        q_push       = loc_valid && !any_idle && !q_full;
        dispatch     = (loc_valid && any_idle) || (net_in_valid && net_in_ready);
        if (loc_valid) begin
            d_op  = loc_op;
            d_tag = loc_tag;
            d_opa = loc_opa;
            d_opb = loc_opb;
        end else begin
            d_op  = net_in_op;
            d_tag = net_in_tag;
            d_opa = net_in_opa;
            d_opb = net_in_opb;
        end
    end

    cad_fifo #(.W(AW), .DEPTH(QDEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   ({loc_op, loc_tag, loc_opa, loc_opb}),
        .pop   (q_pop),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    assign net_out_valid = !q_empty;
    assign q_pop         = net_out_valid && net_out_ready;
    assign {net_out_op, net_out_tag, net_out_opa, net_out_opb} = q_dout;

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        assign start_v[p] = dispatch && (sel == IW'(p));
        cad_proc #(
            .TAG_W   (TAG_W),
            .DATA_W  (DATA_W),
            .ADD_LAT (ADD_LAT),
            .DIV_LAT (DIV_LAT)
        ) u_proc (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start_v[p]),
            .op       (d_op),
            .tag      (d_tag),
            .opa      (d_opa),
            .opb      (d_opb),
            .busy     (busy_v[p]),
            .done     (res_valid[p]),
            .res_tag  (res_tag[p*TAG_W +: TAG_W]),
            .res_data (res_data[p*DATA_W +: DATA_W])
        );
    end
endmodule

// File: rtl/cad_cluster_chk.sv
module cad_cluster_chk #(
    parameter int NPROC = 3,
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             loc_valid,
    input logic             loc_ready,
    input logic             net_in_ready,
    input logic             net_out_valid,
    input logic             net_out_ready,
    input logic [TAG_W-1:0] net_out_tag,
    input logic [NPROC-1:0] res_valid,
    input logic [NPROC-1:0] busy_v
);
    // R5
    single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((res_valid & $past(res_valid)) == '0));

    // R6
    export_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && loc_ready && (&busy_v)) |=> net_out_valid);

    // R7
    stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && !loc_ready) |-> (&busy_v));

    // R8
    remote_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net_in_ready |-> (!loc_valid && !(&busy_v)));

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_out_valid && !net_out_ready) |=> (net_out_valid && $stable(net_out_tag)));
endmodule

bind cluster_dispatch cad_cluster_chk #(.NPROC(NPROC), .TAG_W(TAG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .loc_valid     (loc_valid),
    .loc_ready     (loc_ready),
    .net_in_ready  (net_in_ready),
    .net_out_valid (net_out_valid),
    .net_out_ready (net_out_ready),
    .net_out_tag   (net_out_tag),
    .res_valid     (res_valid),
    .busy_v        (busy_v)
);

// File: tb/cluster_dispatch_test.sv
module cluster_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 3;
    localparam int TW  = 4;
    localparam int DW  = 8;
    localparam int QD  = 3;
    localparam int ALAT = 2;
    localparam int DLAT = 60;
    localparam int AWB = 1 + TW + 2 * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loc_valid = 0, loc_op = 0, net_in_valid = 0, net_in_op = 0, net_out_ready = 0;
    logic [TW-1:0] loc_tag = '0, net_in_tag = '0;
    logic [DW-1:0] loc_opa = '0, loc_opb = '0, net_in_opa = '0, net_in_opb = '0;
    logic loc_ready, net_in_ready, net_out_valid, net_out_op;
    logic [TW-1:0] net_out_tag;
    logic [DW-1:0] net_out_opa, net_out_opb;
    logic [NP-1:0] res_valid;
    logic [NP*TW-1:0] res_tag;
    logic [NP*DW-1:0] res_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cluster_dispatch uut (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_op(loc_op),
        .loc_tag(loc_tag), .loc_opa(loc_opa), .loc_opb(loc_opb),
        .net_in_valid(net_in_valid), .net_in_ready(net_in_ready), .net_in_op(net_in_op),
        .net_in_tag(net_in_tag), .net_in_opa(net_in_opa), .net_in_opb(net_in_opb),
        .net_out_valid(net_out_valid), .net_out_ready(net_out_ready), .net_out_op(net_out_op),
        .net_out_tag(net_out_tag), .net_out_opa(net_out_opa), .net_out_opb(net_out_opb),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit           m_busy [NP];
    int           m_cnt  [NP];
    bit           m_op   [NP];
    logic [TW-1:0] m_tag [NP];
    logic [DW-1:0] m_dat [NP];
    logic [AWB-1:0] m_q [QD];
    int           m_qn = 0;

    function automatic logic [DW-1:0] exp_res(input bit op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        if (!op) return a + b;
        if (b == '0) return '1;
        return a / b;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) m_busy[p] = 0;
        m_qn = 0;
    endtask

    // one cycle: drive at negedge, compare, update model, wait for edge
    task automatic step(input bit lv, input bit lop, input logic [TW-1:0] ltag,
                        input logic [DW-1:0] la, input logic [DW-1:0] lb,
                        input bit nv, input bit nop, input logic [TW-1:0] ntag,
                        input logic [DW-1:0] na, input logic [DW-1:0] nb, input bit ordy);
        bit any_idle;
        int sel;
        bit e_lrdy, e_nrdy;
        loc_valid = lv; loc_op = lop; loc_tag = ltag; loc_opa = la; loc_opb = lb;
        net_in_valid = nv; net_in_op = nop; net_in_tag = ntag; net_in_opa = na; net_in_opb = nb;
        net_out_ready = ordy;
        #1;
        any_idle = 0; sel = 0;
        for (int p = NP - 1; p >= 0; p--) if (!m_busy[p]) begin any_idle = 1; sel = p; end
        e_lrdy = any_idle || (m_qn < QD);
        e_nrdy = any_idle && !lv;
        for (int p = 0; p < NP; p++) begin
            bit ev = m_busy[p] && (m_cnt[p] == 0);
            if (ev) begin
                check(res_valid[p] === 1'b1, "R2", 32'(res_valid[p]), 32'd1);
                if (res_valid[p] === 1'b1) begin
                    check(res_tag[p*TW +: TW] === m_tag[p], m_op[p] ? "R4" : "R3",
                          32'(res_tag[p*TW +: TW]), 32'(m_tag[p]));
                    check(res_data[p*DW +: DW] === m_dat[p], m_op[p] ? "R4" : "R3",
                          32'(res_data[p*DW +: DW]), 32'(m_dat[p]));
                end
            end else begin
                check(res_valid[p] === 1'b0, "R5", 32'(res_valid[p]), 32'd0);
            end
        end
        check(net_out_valid === (m_qn > 0), "R6", 32'(net_out_valid), 32'(m_qn > 0));
        if (m_qn > 0)
            check({net_out_op, net_out_tag, net_out_opa, net_out_opb} === m_q[0], "R9",
                  32'({net_out_op, net_out_tag, net_out_opa, net_out_opb}), 32'(m_q[0]));
        check(loc_ready === e_lrdy, "R7", 32'(loc_ready), 32'(e_lrdy));
        check(net_in_ready === e_nrdy, "R8", 32'(net_in_ready), 32'(e_nrdy));
        // model update
        for (int p = 0; p < NP; p++)
            if (m_busy[p]) begin
                if (m_cnt[p] == 0) m_busy[p] = 0;
                else m_cnt[p]--;
            end
        if (ordy && m_qn > 0) begin
            for (int i = 0; i < QD - 1; i++) m_q[i] = m_q[i+1];
            m_qn--;
        end
        if (lv && any_idle) begin
            m_busy[sel] = 1; m_op[sel] = lop; m_tag[sel] = ltag;
            m_dat[sel] = exp_res(lop, la, lb); m_cnt[sel] = (lop ? DLAT : ALAT) - 1;
        end else if (lv && e_lrdy) begin
            m_q[m_qn] = {lop, ltag, la, lb};
            m_qn++;
        end else if (nv && e_nrdy) begin
            m_busy[sel] = 1; m_op[sel] = nop; m_tag[sel] = ntag;
            m_dat[sel] = exp_res(nop, na, nb); m_cnt[sel] = (nop ? DLAT : ALAT) - 1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rand_phase(input int cycles, input int rdy_pct, input int div_pct);
        for (int c = 0; c < cycles; c++) begin
            bit lv = ($urandom % 100) < 50;
            bit nv = ($urandom % 100) < 50;
            bit lop = ($urandom % 100) < div_pct;
            bit nop = ($urandom % 100) < div_pct;
            logic [DW-1:0] lb = (($urandom % 8) == 0) ? '0 : DW'($urandom);
            logic [DW-1:0] nb = (($urandom % 8) == 0) ? '0 : DW'($urandom);
            step(lv, lop, TW'($urandom), DW'($urandom), lb,
                 nv, nop, TW'($urandom), DW'($urandom), nb,
                 ($urandom % 100) < rdy_pct);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd1987);
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with all inputs low
        check(res_valid === '0, "R1", 32'(res_valid), 32'd0);
        check(net_out_valid === 1'b0, "R1", 32'(net_out_valid), 32'd0);
        check(loc_ready === 1'b1, "R1", 32'(loc_ready), 32'd1);
        check(net_in_ready === 1'b1, "R1", 32'(net_in_ready), 32'd1);

        // R3 directed add on processor 0 (R2 lowest index)
        step(1, 0, 4'h3, 8'd200, 8'd100, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        check(res_valid === 3'b001, "R3", 32'(res_valid), 32'b001);
        check(res_data[DW-1:0] === 8'd44, "R3", 32'(res_data[DW-1:0]), 32'd44);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

        // R8 local wins over network in same cycle
        step(1, 0, 4'h1, 8'd1, 8'd2, 1, 0, 4'h2, 8'd5, 8'd5, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

        // R7 fill: three divides occupy all processors, network stalled
        step(1, 1, 4'h4, 8'd100, 8'd7, 0, 0, 0, 0, 0, 0);
        step(1, 1, 4'h5, 8'd9, 8'd0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 4'h6, 8'd255, 8'd16, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < QD; i++) step(1, 0, TW'(8 + i), DW'(i), DW'(i), 0, 0, 0, 0, 0, 0);
        check(loc_ready === 1'b0, "R7", 32'(loc_ready), 32'd0);
        step(1, 0, 4'hF, 8'd1, 8'd1, 1, 0, 4'hE, 8'd1, 8'd1, 0);
        // drain queue in order, R9
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // wait for divides (R4) to finish
        for (int i = 0; i < DLAT; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // random traffic: heavy backpressure then light
        rand_phase(1500, 20, 30);
        rand_phase(2500, 80, 10);
        for (int i = 0; i < DLAT + 8; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule